// File: doc/BRIEF.md
# Pseudo-Random SRAM Pass Tester

This block exercises an external asynchronous SRAM without a processor touching the memory. A host loads a direction, a 16-bit starting value and a pass count, then pulses start. The block then walks the whole address space as many times as asked. Each access uses the same two-cycle timing the memory sees in normal operation.

In fill direction, every word stored comes from a 16-bit pseudo-random generator. In check direction, every word fetched is folded into a separate 16-bit compacting register whose feedback taps differ from the generator's. Both registers are loaded from the host value once, at the start of a run. They keep running across passes. At the end of every pass the running value is captured for the host, which compares it with a value worked out offline instead of checking each word.

Top module: `mem_lfsr_bist`

## Requirements
- R1: After reset the block is idle: sram_ce_n, sram_we_n and sram_oe_n are high, stat_busy and stat_pass_done are low and stat_passes is 0.
- R2: In fill direction (cfg_mode = 0) the first word stored in a run equals cfg_seed. Each later word is the previous one shifted left by one bit, with the new bit 0 equal to the XOR of old bits 15, 13, 12 and 10 (x^16+x^14+x^13+x^11+1).
- R3: In check direction (cfg_mode = 1) the signature starts at cfg_seed. For every word D fetched it becomes {S[14:0], S[15]^S[14]^S[12]^S[3]} XOR D (x^16+x^15+x^13+x^4+1).
- R4: Each pass visits addresses 0 up to 2^ADDR_W-1 in ascending order, then the address wraps to 0.
- R5: Every access lasts two cycles. In the setup cycle sram_ce_n is low and both strobes are high. In the strobe cycle exactly one of sram_we_n (fill) or sram_oe_n (check) is low, and fetched data is taken at the end of that cycle. Accesses follow each other with no gap, so a run of P passes keeps stat_busy high for exactly 2*P*2^ADDR_W cycles.
- R6: Neither register is reloaded between passes, so pass n+1 continues the sequence where pass n stopped.
- R7: On the clock edge that ends the last access of a pass, stat_result takes the register value after that access, stat_pass_done goes high and stat_passes increments.
- R8: stat_pass_done stays high until a one-cycle stat_rd pulse clears it.
- R9: A cfg_start pulse while stat_busy is high has no effect on the direction, seed or pass count of the run in progress.
- R10: A start with cfg_passes = 0 performs no memory access, leaves stat_busy low and sets stat_passes to 0.
- R11: After the programmed number of passes, stat_busy falls and sram_ce_n returns high on the same edge that ends the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle run request, taken only when idle |
| cfg_mode | input | 1 | 0 fill with generator words, 1 fetch and compact |
| cfg_passes | input | PASS_W | Number of complete passes |
| cfg_seed | input | DATA_W | Starting value for both registers |
| stat_rd | input | 1 | Status read strobe; clears stat_pass_done |
| stat_busy | output | 1 | Run in progress |
| stat_pass_done | output | 1 | Sticky end-of-pass flag |
| stat_passes | output | PASS_W | Passes completed in the current or last run |
| stat_result | output | DATA_W | Register value captured at the last pass end |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | ADDR_W | Memory address |
| sram_wdata | output | DATA_W | Data driven toward the memory |
| sram_rdata | input | DATA_W | Data returned by the memory |

## Verification
Fill runs with several seeds and pass counts show that stored words follow the generator and carry on across passes rather than restarting. Check runs over a known memory image compare every per-pass signature with a bench model. A single flipped memory bit must change the signature, which separates true compaction from a value that ignores the data. Directed cases cover a zero pass count, a start during a run and a pass flag left unread. Randomly drawn seeds, directions and pass counts then mix these paths.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  typedef enum logic {
    MODE_FILL  = 1'b0,
    MODE_CHECK = 1'b1
  } mlb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } mlb_state_e;
endpackage

// File: rtl/mlb_lfsr.sv
module mlb_lfsr #(
  parameter int          W       = 16,
  parameter logic [W-1:0] TAPS   = 16'hB400,
  parameter bit          COMPACT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next_shift
);
  logic [W-1:0] state_q, state_d, stepped;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign stepped = {state_q[W-2:0], fb};

  generate
    if (COMPACT) begin : g_compact
      assign q_next_shift = stepped ^ din;
    end else begin : g_gen
      assign q_next_shift = stepped ^ (din & {W{1'b0}});
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (load)       state_d = load_val;
    else if (shift) state_d = q_next_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             state_q <= '0;
    else if (load || shift) state_q <= state_d;
  end

  assign q = state_q;

  // R6: the register only moves on a load or an access step
  p_hold_between_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(state_q));
endmodule

// File: rtl/mlb_seq.sv
module mlb_seq
  import mlb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PASS_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_mode,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] fill_next,
  input  logic [DATA_W-1:0] sig_next,
  output logic              launch,
  output logic              fill_step,
  output logic              sig_step,
  output logic              busy,
  output logic              pass_flag,
  output logic [PASS_W-1:0] passes_done,
  output logic [DATA_W-1:0] result,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr
);
  mlb_state_e        state_q, state_d;
  mlb_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PASS_W-1:0] target_q, done_q, done_d;
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] result_q;
  logic              start_ok, access_end, pass_end, run_end, last_addr;

  assign start_ok   = cfg_start && (state_q == ST_IDLE);
  assign launch     = start_ok && (cfg_passes != '0);
  assign access_end = (state_q == ST_STROBE);
  assign last_addr  = (addr_q == {ADDR_W{1'b1}});
  assign pass_end   = access_end && last_addr;
  assign run_end    = pass_end && ((done_q + 1'b1) == target_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (launch) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: state_d = run_end ? ST_IDLE : ST_SETUP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    if (launch)          addr_d = '0;
    else if (access_end) addr_d = addr_q + 1'b1;
  end

  always_comb begin
    done_d = done_q;
    if (start_ok)      done_d = '0;
    else if (pass_end) done_d = done_q + 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (pass_end)    flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FILL;
      target_q <= '0;
    end else if (start_ok) begin
      mode_q   <= mlb_mode_e'(cfg_mode);
      target_q <= cfg_passes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    addr_q <= '0;
    else if (launch || access_end) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    done_q <= '0;
    else if (start_ok || pass_end) done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (pass_end) result_q <= (mode_q == MODE_FILL) ? fill_next : sig_next;
  end

  assign fill_step   = access_end && (mode_q == MODE_FILL);
  assign sig_step    = access_end && (mode_q == MODE_CHECK);
  assign busy        = (state_q != ST_IDLE);
  assign pass_flag   = flag_q;
  assign passes_done = done_q;
  assign result      = result_q;
  assign ce_n        = (state_q == ST_IDLE);
  assign we_n        = !(access_end && (mode_q == MODE_FILL));
  assign oe_n        = !(access_end && (mode_q == MODE_CHECK));
  assign addr        = addr_q;

  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (addr_q == '0));

  p_count_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (done_q < target_q));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && cfg_start) |=> ($stable(mode_q) && $stable(target_q)));
endmodule

// File: rtl/mem_lfsr_bist.sv
module mem_lfsr_bist #(
  parameter int               DATA_W   = 16,
  parameter int               ADDR_W   = 6,
  parameter int               PASS_W   = 8,
  parameter logic [DATA_W-1:0] GEN_TAPS = 16'hB400,
  parameter logic [DATA_W-1:0] SIG_TAPS = 16'hD008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_mode,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic [DATA_W-1:0] cfg_seed,
  input  logic              stat_rd,
  output logic              stat_busy,
  output logic              stat_pass_done,
  output logic [PASS_W-1:0] stat_passes,
  output logic [DATA_W-1:0] stat_result,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                core_rst_n;
  logic                launch, fill_step, sig_step;
  logic [DATA_W-1:0]   fill_q, fill_next, sig_q, sig_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_LEN-1];

  mlb_lfsr #(.W(DATA_W), .TAPS(GEN_TAPS), .COMPACT(1'b0)) gen_i (
    .clk(clk), .rst_n(core_rst_n), .load(launch), .load_val(cfg_seed),
    .shift(fill_step), .din('0), .q(fill_q), .q_next_shift(fill_next)
  );

  mlb_lfsr #(.W(DATA_W), .TAPS(SIG_TAPS), .COMPACT(1'b1)) sig_i (
    .clk(clk), .rst_n(core_rst_n), .load(launch), .load_val(cfg_seed),
    .shift(sig_step), .din(sram_rdata), .q(sig_q), .q_next_shift(sig_next)
  );

  mlb_seq #(.ADDR_W(ADDR_W), .PASS_W(PASS_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(core_rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_passes(cfg_passes), .stat_rd(stat_rd), .fill_next(fill_next),
    .sig_next(sig_next), .launch(launch), .fill_step(fill_step),
    .sig_step(sig_step), .busy(stat_busy), .pass_flag(stat_pass_done),
    .passes_done(stat_passes), .result(stat_result), .ce_n(sram_ce_n),
    .we_n(sram_we_n), .oe_n(sram_oe_n), .addr(sram_addr)
  );

  assign sram_wdata = fill_q;

  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!sram_we_n || !sram_oe_n) |-> $past(!sram_ce_n && sram_we_n && sram_oe_n));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!sram_we_n || !sram_oe_n) |=> (sram_we_n && sram_oe_n));

  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sram_we_n || sram_oe_n));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    !stat_busy |-> (sram_ce_n && sram_we_n && sram_oe_n));

  p_sig_frozen_fill_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (stat_busy && !sram_we_n) |=> $stable(sig_q));
endmodule

// File: tb/mem_lfsr_bist_tb_top.sv
module mem_lfsr_bist_tb_top;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int PW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_start = 1'b0;
  logic          cfg_mode = 1'b0;
  logic [PW-1:0] cfg_passes = '0;
  logic [DW-1:0] cfg_seed = '0;
  logic          stat_rd = 1'b0;
  logic          stat_busy, stat_pass_done, sram_ce_n, sram_we_n, sram_oe_n;
  logic [PW-1:0] stat_passes;
  logic [DW-1:0] stat_result, sram_wdata, sram_rdata;
  logic [AW-1:0] sram_addr;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] exp_res [16];
  int tests = 0, fails = 0;
  int busy_cyc = 0, wr_cnt = 0, rd_cnt = 0;

  always #4 clk = ~clk;

  mem_lfsr_bist dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_passes(cfg_passes), .cfg_seed(cfg_seed), .stat_rd(stat_rd),
    .stat_busy(stat_busy), .stat_pass_done(stat_pass_done),
    .stat_passes(stat_passes), .stat_result(stat_result),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_wdata;
  assign sram_rdata = mem[sram_addr];

  always @(negedge clk) begin
    if (stat_busy) busy_cyc++;
    if (!sram_we_n) wr_cnt++;
    if (!sram_oe_n) rd_cnt++;
  end

  function automatic logic [DW-1:0] gstep(input logic [DW-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [DW-1:0] mstep(input logic [DW-1:0] s, input logic [DW-1:0] d);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]} ^ d;
  endfunction

  function automatic logic [DW-1:0] sig_of(input logic [DW-1:0] sd, input int np);
    logic [DW-1:0] m = sd;
    for (int p = 0; p < np; p++)
      for (int a = 0; a < DEPTH; a++) m = mstep(m, mem[a]);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic launch(input logic md, input int np, input logic [DW-1:0] sd);
    @(negedge clk);
    cfg_mode = md; cfg_passes = PW'(np); cfg_seed = sd; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  // full run with per-pass result checks
  task automatic run_check(input logic md, input int np, input logic [DW-1:0] sd);
    logic [DW-1:0] g, m;
    int b0, w0, r0, pidx, bad;
    g = sd; m = sd;
    for (int p = 0; p < np; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        if (!md) begin exp_mem[a] = g; g = gstep(g); end
        else m = mstep(m, mem[a]);
      end
      exp_res[p] = md ? m : g;
    end
    b0 = busy_cyc; w0 = wr_cnt; r0 = rd_cnt; pidx = 0;
    launch(md, np, sd);
    forever begin
      if (stat_pass_done) begin
        chk(stat_result == exp_res[pidx], md ? "R3/R6/R7" : "R2/R6/R7", "pass result",
            stat_result, exp_res[pidx]);
        chk(stat_passes == PW'(pidx + 1), "R7", "pass count", stat_passes, pidx + 1);
        pidx++;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(!stat_pass_done, "R8", "flag cleared by read", stat_pass_done, 0);
      end
      if (!stat_busy) break;
      @(negedge clk);
    end
    chk(pidx == np, "R11", "passes seen", pidx, np);
    chk(sram_ce_n == 1'b1, "R11", "chip select idle", sram_ce_n, 1);
    chk(busy_cyc - b0 == 2 * np * DEPTH, "R5", "busy cycles", busy_cyc - b0, 2 * np * DEPTH);
    chk((md ? rd_cnt - r0 : wr_cnt - w0) == np * DEPTH, "R4/R5", "strobe count",
        md ? rd_cnt - r0 : wr_cnt - w0, np * DEPTH);
    chk((md ? wr_cnt - w0 : rd_cnt - r0) == 0, "R5", "wrong strobe", 
        md ? wr_cnt - w0 : rd_cnt - r0, 0);
    if (!md) begin
      bad = 0;
      for (int a = 0; a < DEPTH; a++) if (mem[a] !== exp_mem[a]) bad++;
      chk(bad == 0, "R2/R4", "memory image mismatches", bad, 0);
      chk(mem[0] == gstep_n(sd, (np - 1) * DEPTH), "R2", "first word of last pass",
          mem[0], gstep_n(sd, (np - 1) * DEPTH));
    end
  endtask

  function automatic logic [DW-1:0] gstep_n(input logic [DW-1:0] s, input int n);
    logic [DW-1:0] r = s;
    for (int i = 0; i < n; i++) r = gstep(r);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [DW-1:0] clean, sd;
    int b0, w0, r0;
    void'($urandom(32'h5EED_1234));
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!stat_busy && !stat_pass_done && stat_passes == 0, "R1", "status idle",
        {stat_busy, stat_pass_done, stat_passes}, 0);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes high",
        {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);

    // directed fill and check runs
    run_check(1'b0, 2, 16'hACE1);
    run_check(1'b1, 1, 16'hACE1);
    run_check(1'b1, 3, 16'h1357);

    // single-bit fault changes the signature (R3)
    clean = sig_of(16'h0F0F, 1);
    mem[17] = mem[17] ^ 16'h0020;
    run_check(1'b1, 1, 16'h0F0F);
    chk(stat_result != clean, "R3", "fault alters signature", stat_result, ~clean);
    mem[17] = mem[17] ^ 16'h0020;

    // R10 zero passes
    b0 = busy_cyc; w0 = wr_cnt; r0 = rd_cnt;
    launch(1'b0, 0, 16'h4444);
    repeat (10) @(negedge clk);
    chk(busy_cyc == b0 && wr_cnt == w0 && rd_cnt == r0, "R10", "no activity",
        busy_cyc - b0 + wr_cnt - w0 + rd_cnt - r0, 0);
    chk(stat_passes == 0, "R10", "pass count zero", stat_passes, 0);

    // R9 start during a run is ignored
    b0 = busy_cyc; r0 = rd_cnt;
    launch(1'b0, 1, 16'hBEEF);
    repeat (20) @(negedge clk);
    cfg_mode = 1'b1; cfg_passes = 8'd5; cfg_seed = 16'h1111; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    while (stat_busy) @(negedge clk);
    chk(busy_cyc - b0 == 2 * DEPTH, "R9", "run length kept", busy_cyc - b0, 2 * DEPTH);
    chk(rd_cnt == r0, "R9", "direction kept", rd_cnt - r0, 0);
    chk(mem[0] == 16'hBEEF, "R9", "seed kept", mem[0], 16'hBEEF);
    chk(stat_result == gstep_n(16'hBEEF, DEPTH), "R9", "result of original run",
        stat_result, gstep_n(16'hBEEF, DEPTH));

    // R8 flag stays until read
    repeat (6) @(negedge clk);
    chk(stat_pass_done, "R8", "flag held unread", stat_pass_done, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk(!stat_pass_done, "R8", "flag cleared", stat_pass_done, 0);

    // random runs
    for (int k = 0; k < 5; k++) begin
      sd = DW'($urandom_range(1, 16'hFFFF));
      run_check(1'(($urandom() >> 3) & 1), 1 + ($urandom() % 3), sd);
    end

    summary();
  end
endmodule